// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Interface

This block is the synchronous digital front end of a two-channel, 16-bit parallel-load converter. A host drives a data word, a two-bit channel address, an active-low write strobe, a load strobe, an active-low clear and a preset-select level. These pins are asynchronous to the system clock. Every one of them passes through a two-flop synchronizer before any decision is made.

Each channel holds its code in two stages. A staging register captures the bus. An output register drives the converter core and publishes the code on the block's outputs. The address picks channel A, channel B, both channels or no channel. The strobe combination picks one of four actions: capture into staging, move staging to output, pass the bus straight through both stages, or do nothing.

When the write strobe and the load strobe are wired together as a single pulse, the low phase fills the staging register and the return high moves that value to the output. The move happens once, on the cycle a strobe rises. Holding both strobes high does not repeat it. The clear input and the system reset both force all four registers to a preset. The preset is zero scale or midscale, chosen by the preset-select level.

Top module: `dual_dac_frontend`

## Requirements
- R1: While the system reset `rst` is high, all four registers load the preset: 0x0000 when `mid_preset` is 0, 0x8000 when it is 1. Both outputs show that preset in the first cycle after reset.
- R2: While the synchronized `clear_n` is 0, all four registers load the preset, whatever the strobes and the address. The preset is 0x0000 or 0x8000 as the synchronized `mid_preset` selects.
- R3: With `wr_strobe_n` = 0 and `load_strobe` = 0, the staging registers of the addressed channels take `bus_data`. The outputs do not change.
- R4: When both strobes are 1 and at least one of them was 0 in the previous synchronized sample, the output registers of the addressed channels take their staging values.
- R5: Address decoding on `bus_addr`: 2'b00 selects channel A, 2'b11 selects channel B, 2'b10 selects both, and 2'b01 selects none. With 2'b01, no register changes under any strobe combination.
- R6: With `wr_strobe_n` = 0 and `load_strobe` = 1, both stages of the addressed channels follow `bus_data`, so the outputs track the bus.
- R7: A pulse in which both strobes fall and rise together loads the staging register on the low phase and moves it to the output on the return high.
- R8: With `wr_strobe_n` = 1 and `load_strobe` = 0, no register changes.
- R9: The output move happens once per strobe rise. Changing the address while both strobes stay high moves nothing into the newly addressed channel.
- R10: A change on the pins reaches `code_a`/`code_b` on the third rising clock edge after it is applied: two synchronizer edges plus one register edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_data | input | 16 | Parallel code word |
| bus_addr | input | 2 | Channel address |
| wr_strobe_n | input | 1 | Write strobe, active low |
| load_strobe | input | 1 | Load strobe |
| clear_n | input | 1 | Clear to preset, active low |
| mid_preset | input | 1 | Preset select: 0 zero scale, 1 midscale |
| code_a | output | 16 | Channel A output-register code |
| code_b | output | 16 | Channel B output-register code |

## Verification
Staging registers have no port of their own. A corrupted staging value therefore stays hidden until the next output move, which can come many cycles later. The bench exposes staging contents by following each capture-only or ignored step with a deliberate move, and then compares the outputs.

A wrong address decode, a stuck edge detector or a lost clear shows on the outputs three clock edges after the stimulus. The bench samples exactly there, and also one edge earlier to pin down the latency.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  typedef enum logic [1:0] {
    ADR_CH_A = 2'b00,
    ADR_NONE = 2'b01,
    ADR_BOTH = 2'b10,
    ADR_CH_B = 2'b11
  } fe_adr_e;

  typedef struct packed {
    logic clr;
    logic cap;
    logic xfer;
    logic pass;
  } fe_op_t;

  localparam int unsigned FE_NCH = 2;

  // bit 0 = channel A, bit 1 = channel B
  function automatic logic [FE_NCH-1:0] fe_chan_hit(input logic [1:0] adr);
    case (fe_adr_e'(adr))
      ADR_CH_A: fe_chan_hit = 2'b01;
      ADR_CH_B: fe_chan_hit = 2'b10;
      ADR_BOTH: fe_chan_hit = 2'b11;
      default:  fe_chan_hit = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_in;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[gi] <= RST_VAL;
        else     stg[gi] <= stg[gi-1];
      end
    end
  endgenerate

  assign q_out = stg[STAGES-1];

endmodule

// File: rtl/fe_decode.sv
module fe_decode
  import dac_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n_s,
  input  logic              ld_s,
  input  logic              clr_n_s,
  input  logic [1:0]        adr_s,
  output fe_op_t            op,
  output logic [FE_NCH-1:0] hit
);

  logic wr_n_prev, ld_prev;
  logic rise_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_prev <= 1'b1;
      ld_prev   <= 1'b1;
    end else begin
      wr_n_prev <= wr_n_s;
      ld_prev   <= ld_s;
    end
  end

  assign rise_any = (wr_n_s && !wr_n_prev) || (ld_s && !ld_prev);

  always_comb begin
    op.clr  = !clr_n_s;
    op.cap  = !wr_n_s && !ld_s;
    op.pass = !wr_n_s &&  ld_s;
    op.xfer =  wr_n_s &&  ld_s && rise_any;
  end

  assign hit = fe_chan_hit(adr_s);

  // R3
  op_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op.cap, op.xfer, op.pass}));

  // R9
  xfer_once_chk: assert property (@(posedge clk) disable iff (rst)
    op.xfer |=> !op.xfer);

endmodule

// File: rtl/fe_chan.sv
module fe_chan
  import dac_fe_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         por_mid,
  input  logic         mid_s,
  input  fe_op_t       op,
  input  logic         hit,
  input  logic [W-1:0] din,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] out_q
);

  localparam logic [W-2:0] LOW_ZERO = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= {por_mid, LOW_ZERO};
      out_q   <= {por_mid, LOW_ZERO};
    end else if (op.clr) begin
      stage_q <= {mid_s, LOW_ZERO};
      out_q   <= {mid_s, LOW_ZERO};
    end else if (hit) begin
      if (op.pass) begin
        stage_q <= din;
        out_q   <= din;
      end else begin
        if (op.cap)  stage_q <= din;
        if (op.xfer) out_q   <= stage_q;
      end
    end
  end

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    op.clr |=> (out_q == {$past(mid_s), LOW_ZERO}) && (stage_q == out_q));

  // R5
  no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!op.clr && !hit) |=> ($stable(out_q) && $stable(stage_q)));

  // R6
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!op.clr && hit && op.pass) |=> (out_q == $past(din)));

  // R4
  xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (!op.clr && hit && op.xfer) |=> (out_q == $past(stage_q)));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!op.clr && !op.cap && !op.xfer && !op.pass) |=> ($stable(out_q) && $stable(stage_q)));

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op.clr && op.cap) |=> $stable(out_q));

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        bus_addr,
  input  logic              wr_strobe_n,
  input  logic              load_strobe,
  input  logic              clear_n,
  input  logic              mid_preset,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b
);

  localparam int unsigned CTRL_W = 6;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = {ADR_NONE, 1'b1, 1'b1, 1'b1, 1'b0};

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic [DATA_W-1:0] data_s;
  logic [1:0]        adr_s;
  logic              wr_n_s, ld_s, clr_n_s, mid_s;
  fe_op_t            op;
  logic [FE_NCH-1:0] hit;
  logic [DATA_W-1:0] stage_v [FE_NCH];
  logic [DATA_W-1:0] out_v   [FE_NCH];

  assign ctrl_raw = {bus_addr, wr_strobe_n, load_strobe, clear_n, mid_preset};

  fe_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk(clk), .rst(rst), .d_in(ctrl_raw), .q_out(ctrl_s)
  );

  fe_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst(rst), .d_in(bus_data), .q_out(data_s)
  );

  assign {adr_s, wr_n_s, ld_s, clr_n_s, mid_s} = ctrl_s;

  fe_decode u_dec (
    .clk(clk), .rst(rst), .wr_n_s(wr_n_s), .ld_s(ld_s), .clr_n_s(clr_n_s),
    .adr_s(adr_s), .op(op), .hit(hit)
  );

  genvar gc;
  generate
    for (gc = 0; gc < FE_NCH; gc++) begin : g_chan
      fe_chan #(.W(DATA_W)) u_chan (
        .clk(clk), .rst(rst), .por_mid(mid_preset), .mid_s(mid_s), .op(op),
        .hit(hit[gc]), .din(data_s), .stage_q(stage_v[gc]), .out_q(out_v[gc])
      );
    end
  endgenerate

  assign code_a = out_v[0];
  assign code_b = out_v[1];

endmodule

// File: tb/tb_dual_dac_frontend.sv
`timescale 1ns/1ps
module tb_dual_dac_frontend;

  localparam int unsigned DW = 16;
  localparam int unsigned SETTLE = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] bus_data;
  logic [1:0]    bus_addr;
  logic          wr_strobe_n, load_strobe, clear_n, mid_preset;
  logic [DW-1:0] code_a, code_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_frontend dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .bus_addr(bus_addr),
    .wr_strobe_n(wr_strobe_n), .load_strobe(load_strobe), .clear_n(clear_n),
    .mid_preset(mid_preset), .code_a(code_a), .code_b(code_b)
  );

  task automatic check(input string req, input logic [DW-1:0] ea, input logic [DW-1:0] eb);
    n_chk++;
    if (code_a !== ea || code_b !== eb) begin
      n_fail++;
      $display("FAIL %s: code_a=%h code_b=%h expected %h %h", req, code_a, code_b, ea, eb);
    end
  endtask

  task automatic drive(input logic [DW-1:0] d, input logic [1:0] a, input logic w, input logic l);
    @(negedge clk);
    bus_data = d; bus_addr = a; wr_strobe_n = w; load_strobe = l;
    repeat (SETTLE) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [DW-1:0] d, input logic [1:0] a);
    drive(d, a, 1'b0, 1'b0);
    drive(d, a, 1'b1, 1'b1);
  endtask

  task automatic do_reset(input logic mid);
    @(negedge clk);
    rst = 1'b1; mid_preset = mid; clear_n = 1'b1;
    wr_strobe_n = 1'b1; load_strobe = 1'b1; bus_addr = 2'b01; bus_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R1 zero preset", 16'h0000, 16'h0000);
    do_reset(1'b1);
    check("R1 mid preset", 16'h8000, 16'h8000);
  endtask

  task automatic t_capture_move();
    drive(16'h1111, 2'b00, 1'b0, 1'b0);
    check("R3 capture leaves output", 16'h8000, 16'h8000);
    drive(16'h1111, 2'b00, 1'b1, 1'b0);
    drive(16'h1111, 2'b00, 1'b1, 1'b1);
    check("R4 move on ld rise", 16'h1111, 16'h8000);
  endtask

  task automatic t_ignore();
    drive(16'h2222, 2'b00, 1'b1, 1'b0);
    check("R8 wr high ld low output", 16'h1111, 16'h8000);
    drive(16'h2222, 2'b00, 1'b1, 1'b1);
    check("R8 staging untouched", 16'h1111, 16'h8000);
  endtask

  task automatic t_address();
    pulse(16'h3333, 2'b10);
    check("R7 R5 both via pulse", 16'h3333, 16'h3333);
    pulse(16'h4444, 2'b11);
    check("R5 channel B", 16'h3333, 16'h4444);
    pulse(16'h5555, 2'b01);
    check("R5 none pulse", 16'h3333, 16'h4444);
    drive(16'h5555, 2'b01, 1'b0, 1'b1);
    check("R5 none transparent", 16'h3333, 16'h4444);
    drive(16'h5555, 2'b01, 1'b1, 1'b1);
  endtask

  task automatic t_edge_once();
    drive(16'h7777, 2'b11, 1'b0, 1'b0);
    drive(16'h7777, 2'b11, 1'b1, 1'b0);
    drive(16'h6666, 2'b00, 1'b0, 1'b0);
    drive(16'h6666, 2'b00, 1'b1, 1'b0);
    drive(16'h6666, 2'b00, 1'b1, 1'b1);
    check("R4 move A only", 16'h6666, 16'h4444);
    drive(16'h6666, 2'b11, 1'b1, 1'b1);
    check("R9 no move on addr change", 16'h6666, 16'h4444);
    drive(16'h6666, 2'b11, 1'b1, 1'b0);
    drive(16'h6666, 2'b11, 1'b1, 1'b1);
    check("R9 move B on new rise", 16'h6666, 16'h7777);
  endtask

  task automatic t_transparent();
    @(negedge clk);
    bus_data = 16'h9ABC; bus_addr = 2'b10; wr_strobe_n = 1'b0; load_strobe = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R10 unchanged after two edges", 16'h6666, 16'h7777);
    @(posedge clk);
    #1 check("R10 R6 visible on third edge", 16'h9ABC, 16'h9ABC);
    drive(16'h1234, 2'b10, 1'b0, 1'b1);
    check("R6 follows bus", 16'h1234, 16'h1234);
    drive(16'h1234, 2'b10, 1'b1, 1'b1);
    check("R6 hold after release", 16'h1234, 16'h1234);
  endtask

  task automatic t_clear();
    @(negedge clk);
    mid_preset = 1'b1; clear_n = 1'b0;
    drive(16'hFFFF, 2'b10, 1'b0, 1'b0);
    check("R2 clear mid over strobes", 16'h8000, 16'h8000);
    @(negedge clk);
    mid_preset = 1'b0;
    drive(16'hFFFF, 2'b10, 1'b1, 1'b1);
    check("R2 clear zero", 16'h0000, 16'h0000);
    @(negedge clk);
    clear_n = 1'b1;
    drive(16'hFFFF, 2'b10, 1'b1, 1'b1);
    drive(16'hFFFF, 2'b10, 1'b1, 1'b0);
    drive(16'hFFFF, 2'b10, 1'b1, 1'b1);
    check("R2 staging cleared", 16'h0000, 16'h0000);
  endtask

  initial begin
    rst = 1'b1; bus_data = '0; bus_addr = 2'b01;
    wr_strobe_n = 1'b1; load_strobe = 1'b1; clear_n = 1'b1; mid_preset = 1'b0;
    t_reset();
    t_capture_move();
    t_ignore();
    t_address();
    t_edge_once();
    t_transparent();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule